// File: doc/BRIEF.md
# Multicycle Memory Block-Copy Sequencer

This block copies a run of 32-bit words from one memory region to another through a single shared memory port. A start pulse in the idle state captures three operands: the byte address of the first source word, the byte address of the first destination word and the number of words to move. The sequencer then walks a fixed series of microsteps. It loads the count into the ALU result register, tests it for zero, reads a source word into the memory-data register, writes that register to the destination, and then updates the source pointer, the destination pointer and the remaining count.

Every value that feeds a working register or the memory address passes through the ALU result register. Each value is therefore usable one cycle after it is computed, and a step only ever sees register contents from before the current clock edge. The next-step choice has two conditional outcomes: exit when the result register is zero, or continue when it is nonzero. A count of zero is caught before any memory access. Each copied word costs eight cycles. A whole job takes 2 + 8·N cycles from the accepting edge to the done pulse.

Top module: `blk_copy_seq`

## Requirements
- R1: While reset is high and after it is released, the block is idle: busy=0, done=0, mem_re=0, mem_we=0 and mem_addr=0. A reset asserted in the middle of a copy stops the copy and makes no further memory access.
- R2: start is sampled only while idle. A start pulse while busy, with any operand values, has no effect on the running copy: it causes no extra access, no change of addresses and no change of length.
- R3: A word count of 0 makes no memory read or write, and done follows the accepting edge after exactly 2 further clock edges.
- R4: For word k (k = 0..N-1), the read address is src_addr + 4k and the write address is dst_addr + 4k. Byte addresses step by 4 per 32-bit word.
- R5: mem_re and mem_we are never high in the same cycle.
- R6: Each write carries the word returned for the read two cycles earlier (read latency of one cycle, captured in the memory-data register). After the job, the destination words equal the source words.
- R7: done is high for exactly one cycle and then the block is idle. busy is high in every cycle from the accepting edge up to and including the done cycle, and low in the cycle after done.
- R8: A job of N words takes exactly 2 + 8·N clock edges from the accepting edge until done is high.
- R9: Exactly N reads and N writes occur, and no write touches an address outside [dst_addr, dst_addr + 4N).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy; sampled only when idle |
| src_addr | input | 32 | Byte address of first source word |
| dst_addr | input | 32 | Byte address of first destination word |
| word_count | input | 16 | Number of words to copy |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 32 | Memory byte address (0 when no access) |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 32 | Write data (memory-data register) |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_re |

## Verification
On every cycle the assertions check the exclusivity of read and write, that each write comes two cycles after a read and carries the word returned for that read, and that done is a single-cycle pulse followed by idle. They also check that a zero count reaches done with no read. Address sequencing, exact access counts, the cycle latency for several lengths, the fact that a start while busy is ignored, recovery from a reset mid-copy and the final memory contents depend on a memory model and whole jobs, so only the bench scenarios can show them.

// File: rtl/blk_copy_pkg.sv
package blk_copy_pkg;

  // Microstep states of the copy sequence
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_LDCNT  = 4'd1,   // result <= count
    ST_TSTCNT = 4'd2,   // branch on result == 0
    ST_SRCA   = 4'd3,   // result <= source pointer
    ST_READ   = 4'd4,   // memory read at result
    ST_CAPT   = 4'd5,   // mdr <= read data, result <= destination pointer
    ST_WRITE  = 4'd6,   // memory write of mdr at result
    ST_INCS   = 4'd7,   // result <= source + step
    ST_WSRC   = 4'd8,   // source <= result, result <= destination + step
    ST_WDST   = 4'd9,   // destination <= result, result <= count - 1
    ST_WCNT   = 4'd10,  // count <= result, branch on result
    ST_DONE   = 4'd11
  } step_e;

  // Source selection for the ALU result register
  typedef enum logic [2:0] {
    RES_KEEP      = 3'd0,
    RES_COUNT     = 3'd1,
    RES_SRC       = 3'd2,
    RES_DST       = 3'd3,
    RES_SRC_NEXT  = 3'd4,
    RES_DST_NEXT  = 3'd5,
    RES_COUNT_DEC = 3'd6
  } res_sel_e;

  // One decoded microstep worth of control
  typedef struct packed {
    res_sel_e res_sel;
    logic     load_ops;
    logic     src_wr;
    logic     dst_wr;
    logic     cnt_wr;
    logic     mdr_wr;
    logic     rd;
    logic     wr;
  } uop_t;

endpackage

// File: rtl/blk_copy_ctrl.sv
module blk_copy_ctrl
  import blk_copy_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic res_zero,
  output uop_t uop,
  output logic busy,
  output logic done
);

  step_e state_q, state_d;

  // named events for checking
  logic accept;
  logic exit_taken;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    uop     = '0;
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          uop.load_ops = 1'b1;
          state_d      = ST_LDCNT;
        end
      end
      ST_LDCNT: begin
        uop.res_sel = RES_COUNT;
        state_d     = ST_TSTCNT;
      end
      ST_TSTCNT: begin
        state_d = res_zero ? ST_DONE : ST_SRCA;
      end
      ST_SRCA: begin
        uop.res_sel = RES_SRC;
        state_d     = ST_READ;
      end
      ST_READ: begin
        uop.rd  = 1'b1;
        state_d = ST_CAPT;
      end
      ST_CAPT: begin
        uop.mdr_wr  = 1'b1;
        uop.res_sel = RES_DST;
        state_d     = ST_WRITE;
      end
      ST_WRITE: begin
        uop.wr  = 1'b1;
        state_d = ST_INCS;
      end
      ST_INCS: begin
        uop.res_sel = RES_SRC_NEXT;
        state_d     = ST_WSRC;
      end
      ST_WSRC: begin
        uop.src_wr  = 1'b1;
        uop.res_sel = RES_DST_NEXT;
        state_d     = ST_WDST;
      end
      ST_WDST: begin
        uop.dst_wr  = 1'b1;
        uop.res_sel = RES_COUNT_DEC;
        state_d     = ST_WCNT;
      end
      ST_WCNT: begin
        uop.cnt_wr = 1'b1;
        state_d    = res_zero ? ST_DONE : ST_SRCA;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign accept     = (state_q == ST_IDLE) && start;
  assign exit_taken = ((state_q == ST_TSTCNT) || (state_q == ST_WCNT)) && res_zero;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  // R3
  zero_exit_chk: assert property (@(posedge clk) disable iff (rst)
    exit_taken |=> done);

endmodule

// File: rtl/blk_copy_regs.sv
module blk_copy_regs
  import blk_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int RES_W  = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  uop_t              uop,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [RES_W-1:0]  res_q,
  output logic              res_zero,
  output logic [DATA_W-1:0] mdr_q
);

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [RES_W-1:0]  res_d;

  // pointer advance by one word in bytes
  function automatic logic [ADDR_W-1:0] ptr_advance(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(STEP);
  endfunction

  // remaining count after one word
  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_comb begin
    case (uop.res_sel)
      RES_COUNT:     res_d = RES_W'(cnt_q);
      RES_SRC:       res_d = RES_W'(src_q);
      RES_DST:       res_d = RES_W'(dst_q);
      RES_SRC_NEXT:  res_d = RES_W'(ptr_advance(src_q));
      RES_DST_NEXT:  res_d = RES_W'(ptr_advance(dst_q));
      RES_COUNT_DEC: res_d = RES_W'(count_after(cnt_q));
      default:       res_d = res_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      res_q <= res_d;
      if (uop.load_ops) begin
        src_q <= src_in;
        dst_q <= dst_in;
        cnt_q <= cnt_in;
      end
      if (uop.src_wr) src_q <= res_q[ADDR_W-1:0];
      if (uop.dst_wr) dst_q <= res_q[ADDR_W-1:0];
      if (uop.cnt_wr) cnt_q <= res_q[CNT_W-1:0];
      if (uop.mdr_wr) mdr_q <= rdata;
    end
  end

  assign res_zero = (res_q == '0);

  // R4
  src_step_chk: assert property (@(posedge clk) disable iff (rst)
    uop.src_wr |=> (src_q == $past(res_q[ADDR_W-1:0])));

endmodule

// File: rtl/blk_copy_memif.sv
module blk_copy_memif #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [RES_W-1:0]  res_q,
  input  logic [DATA_W-1:0] mdr_q,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata
);

  logic access;

  assign access    = rd || wr;
  assign mem_re    = rd;
  assign mem_we    = wr;
  assign mem_addr  = access ? res_q[ADDR_W-1:0] : '0;
  assign mem_wdata = mdr_q;

  // R5
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_re, 2));

  // R6
  write_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == $past(mem_rdata)));

endmodule

// File: rtl/blk_copy_seq.sv
module blk_copy_seq
  import blk_copy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  word_count,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int RES_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W;
  localparam int STEP  = DATA_W / 8;

  uop_t              uop;
  logic              res_zero;
  logic [RES_W-1:0]  res_q;
  logic [DATA_W-1:0] mdr_q;
  logic              accept;

  blk_copy_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .res_zero (res_zero),
    .uop      (uop),
    .busy     (busy),
    .done     (done)
  );

  blk_copy_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .RES_W  (RES_W),
    .STEP   (STEP)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .uop      (uop),
    .src_in   (src_addr),
    .dst_in   (dst_addr),
    .cnt_in   (word_count),
    .rdata    (mem_rdata),
    .res_q    (res_q),
    .res_zero (res_zero),
    .mdr_q    (mdr_q)
  );

  blk_copy_memif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .RES_W  (RES_W)
  ) u_memif (
    .clk       (clk),
    .rst       (rst),
    .rd        (uop.rd),
    .wr        (uop.wr),
    .res_q     (res_q),
    .mdr_q     (mdr_q),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  assign accept = start && !busy;

  // R3
  zero_count_done_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (word_count == '0)) |-> ##3 done);

  // R3
  zero_count_noread_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (word_count == '0)) |=> (!mem_re && !mem_we));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_re && !mem_we && (mem_addr == '0)));

endmodule

// File: tb/blk_copy_seq_tb.sv
`timescale 1ns/1ps
module blk_copy_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_addr = '0, dst_addr = '0;
  logic [15:0] word_count = '0;
  logic        busy, done, mem_re, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  blk_copy_seq dut_i (
    .clk(clk), .rst(rst), .start(start),
    .src_addr(src_addr), .dst_addr(dst_addr), .word_count(word_count),
    .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [256];
  int total = 0, fails = 0;
  int rd_cnt, wr_cnt, addr_err, out_err, data_err, both_err;
  logic [31:0] exp_rd, exp_wr, win_lo, win_hi, last_rd;

  function automatic logic [31:0] pattern(input int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0101_0107);
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = pattern(i);
  endtask

  task automatic clear_mon();
    rd_cnt = 0; wr_cnt = 0; addr_err = 0; out_err = 0; data_err = 0; both_err = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // behavioural memory with one-cycle read latency, plus access monitor
  always @(posedge clk) begin
    if (mem_re) begin
      rd_cnt++;
      if (mem_addr != exp_rd) addr_err++;
      exp_rd = exp_rd + 4;
      last_rd = mem[mem_addr[9:2]];
      mem_rdata <= mem[mem_addr[9:2]];
    end
    if (mem_we) begin
      wr_cnt++;
      if (mem_addr != exp_wr) addr_err++;
      if (mem_addr < win_lo || mem_addr >= win_hi) out_err++;
      if (mem_wdata != last_rd) data_err++;
      exp_wr = exp_wr + 4;
      mem[mem_addr[9:2]] = mem_wdata;
    end
    if (mem_re && mem_we) both_err++;
  end

  // source word, destination word, count
  localparam int VEC_N = 5;
  localparam int VEC [VEC_N][3] = '{
    '{0,  64,  0},
    '{4,  80,  1},
    '{8,  96,  5},
    '{16, 120, 3},
    '{30, 150, 12}
  };

  task automatic run_copy(input int s, input int d, input int n, input bit poke);
    int edges, busy_gap, mism;
    bit fin;
    init_mem();
    clear_mon();
    exp_rd = 32'(s * 4); exp_wr = 32'(d * 4);
    win_lo = 32'(d * 4); win_hi = 32'((d + n) * 4);
    @(negedge clk);
    src_addr = 32'(s * 4); dst_addr = 32'(d * 4); word_count = 16'(n); start = 1'b1;
    @(posedge clk);
    edges = 0; busy_gap = 0; fin = 0;
    for (int guard = 0; guard < 5000; guard++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && edges == 5) begin
        // R2: start with other operands while busy
        start = 1'b1; src_addr = 32'd800; dst_addr = 32'd800; word_count = 16'd7;
      end
      if (done) begin fin = 1; break; end
      if (!busy) busy_gap++;
      @(posedge clk);
      edges++;
    end
    start = 1'b0;
    check(fin, "R7", "done reached", fin, 1);
    check(busy, "R7", "busy during done cycle", busy, 1);
    check(busy_gap == 0, "R7", "cycles with busy low before done", busy_gap, 0);
    check(edges == 2 + 8 * n, (n == 0) ? "R3" : "R8", "edges to done", edges, 2 + 8 * n);
    check(rd_cnt == n, (n == 0) ? "R3" : "R9", "read count", rd_cnt, n);
    check(wr_cnt == n, (n == 0) ? "R3" : "R9", "write count", wr_cnt, n);
    check(addr_err == 0, "R4", "address sequence errors", addr_err, 0);
    check(out_err == 0, poke ? "R2" : "R9", "writes outside destination", out_err, 0);
    check(data_err == 0, "R6", "write data not last read", data_err, 0);
    check(both_err == 0, "R5", "read and write together", both_err, 0);
    mism = 0;
    for (int k = 0; k < n; k++) if (mem[d + k] != pattern(s + k)) mism++;
    check(mism == 0, "R6", "destination words differing from source", mism, 0);
    check(mem[d + n] == pattern(d + n), "R9", "word past destination untouched",
          mem[d + n], pattern(d + n));
    @(negedge clk);
    check(!done && !busy, "R7", "idle after done (busy,done)", {busy, done}, 0);
  endtask

  initial begin
    #3_000_000;
    total++; fails++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    init_mem();
    clear_mon();
    exp_rd = '0; exp_wr = '0; win_lo = '0; win_hi = '0; last_rd = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(!busy && !done && !mem_re && !mem_we && mem_addr == 0, "R1",
          "state during reset", {busy, done, mem_re, mem_we}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done && mem_addr == 0, "R1", "idle after reset", {busy, done}, 0);

    for (int v = 0; v < VEC_N; v++) run_copy(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);

    // R2: start pulse while busy is ignored
    run_copy(10, 200, 2, 1'b1);

    // R1: reset in the middle of a copy
    init_mem();
    clear_mon();
    exp_rd = 32'd0; exp_wr = 32'd400; win_lo = 32'd400; win_hi = 32'd416;
    @(negedge clk);
    src_addr = 32'd0; dst_addr = 32'd400; word_count = 16'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(!busy && !done, "R1", "idle after mid-copy reset", {busy, done}, 0);
    clear_mon();
    repeat (20) @(negedge clk);
    check(rd_cnt == 0 && wr_cnt == 0, "R1", "accesses after mid-copy reset",
          rd_cnt + wr_cnt, 0);
    check(!busy, "R1", "stays idle after reset", busy, 0);

    // fresh job after reset behaves normally
    run_copy(2, 40, 4, 1'b0);

    finish_run();
  end

endmodule